// File: doc/BRIEF.md
# Destination Lookup Table with Message Tap Redirect

This block sits in each tile of a tiled on-chip network. A hardware task sends every outgoing message to one of its logical ports. The block turns that port number into the physical tile address of the task that currently receives it. The operating system owns the mapping. It rewrites entries through a host write port whenever a task is placed, removed or moved to another tile. Lookups are presented on one port and answered from a register one cycle later.

For debugging, the host can tap a single port. When the tap is armed, the block copies the port's real destination into a shadow register. It then replaces the live entry with the address of the interface tile, which hands the traffic to the operating system. The shadow value is visible on an output, so software can forward every captured message to its real receiver.

When the tap is released, the real destination goes back into the live entry in one cycle, and traffic again flows directly from tile to tile. Only one port can be tapped at a time. An attempt to tap a second port is refused and recorded in a sticky error flag.

Top module: `route_map_tap`

## Requirements
- R1: While reset is asserted, and after it, every live entry holds RESET_DEST (default 0). After reset, lookupValid is 0, sniffActive is 0, sniffErr is 0 and backupDest is 0.
- R2: lookupValid equals lookupReq of the previous cycle. lookupDest then holds the live entry of the port presented in that cycle, as it stood before any update at the same clock edge.
- R3: A host write (wrEn, wrPort, wrDest) to a port that is not tapped replaces that port's live entry from the next cycle on.
- R4: Arming the tap (sniffArm with sniffPort) while no tap is active has three effects from the next cycle on. The port's real destination moves into the shadow register. The port's live entry reads IFACE_TILE (default 15). sniffActive is 1 and sniffedPort shows the port. A host write to that port in the same cycle counts as the real destination.
- R5: backupDest shows the real destination of the tapped port while sniffActive is 1, and 0 while it is 0.
- R6: A host write to the tapped port updates backupDest and leaves the live entry at IFACE_TILE.
- R7: sniffDisarm while a tap is active restores the real destination into the live entry in a single cycle. A host write to that port in the same cycle wins. From the next cycle on, sniffActive is 0.
- R8: sniffArm while a tap is active is ignored: the tapped port and all entries stay as they were. It sets sniffErr, which stays 1 until reset.
- R9: While a port is tapped, lookups of every other port return their real destinations.
- R10: sniffDisarm while no tap is active changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupReq | input | 1 | Lookup request |
| lookupPort | input | PORT_W | Logical port to translate |
| lookupValid | output | 1 | Lookup result valid (one cycle after request) |
| lookupDest | output | DEST_W | Physical tile address returned |
| wrEn | input | 1 | Host write strobe |
| wrPort | input | PORT_W | Port written by the host |
| wrDest | input | DEST_W | New real destination |
| sniffArm | input | 1 | Arm the tap on sniffPort |
| sniffDisarm | input | 1 | Release the active tap |
| sniffPort | input | PORT_W | Port to tap |
| sniffActive | output | 1 | A tap is in place |
| sniffedPort | output | PORT_W | Port currently tapped |
| backupDest | output | DEST_W | Shadow copy of the tapped port's real destination |
| sniffErr | output | 1 | Sticky: arm attempted while a tap was active |

## Verification
The bench uses the default parameters: 8 ports, 4-bit addresses, interface tile 15 and reset destination 0. With only 8 ports, random arms, writes and lookups often hit the tapped port itself. This covers the cases where an arm or a release falls in the same cycle as a write to that port. Because a 4-bit address can also hold 15, the bench writes that value as a real destination. A redirect and a real route to the interface tile then look the same on lookupDest, and only sniffActive and backupDest tell them apart.

// File: rtl/route_map_pkg.sv
`timescale 1ns/1ps
package route_map_pkg;
  // Strobes issued by the control half to the datapath half, one clock each.
  typedef struct packed {
    logic arm;       // capture shadow copy and force the redirect
    logic disarm;    // restore shadow copy into the live entry
    logic liveWr;    // host write lands in the live table
    logic backupWr;  // host write lands in the shadow register
    logic errSet;    // refused arm request
  } mapStrobe_t;

  typedef enum logic {
    TAP_IDLE = 1'b0,
    TAP_ON   = 1'b1
  } tapState_t;
endpackage

// File: rtl/route_map_ctrl.sv
`timescale 1ns/1ps
module route_map_ctrl
  import route_map_pkg::*;
#(
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sniffArm,
  input  logic              sniffDisarm,
  input  logic [PORT_W-1:0] sniffPort,
  input  logic              wrEn,
  input  logic [PORT_W-1:0] wrPort,
  output mapStrobe_t        strobe,
  output logic [PORT_W-1:0] selPort,
  output logic              sniffActive,
  output logic [PORT_W-1:0] sniffedPort,
  output logic              sniffErr
);

  tapState_t         stateQ;
  logic [PORT_W-1:0] portQ;
  logic              errQ;
  logic              writeHitsSel;

  always_comb begin
    strobe = '0;
    if (stateQ == TAP_ON) begin
      selPort       = portQ;
      strobe.disarm = sniffDisarm;
      strobe.errSet = sniffArm;
    end else begin
      selPort    = sniffPort;
      strobe.arm = sniffArm;
    end
    writeHitsSel    = wrEn && (wrPort == selPort);
    strobe.backupWr = writeHitsSel &&
                      (strobe.arm || ((stateQ == TAP_ON) && !strobe.disarm));
    strobe.liveWr   = wrEn && !strobe.backupWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= TAP_IDLE;
      portQ  <= '0;
      errQ   <= 1'b0;
    end else begin
      if (strobe.arm) begin
        stateQ <= TAP_ON;
        portQ  <= sniffPort;
      end else if (strobe.disarm) begin
        stateQ <= TAP_IDLE;
      end
      if (strobe.errSet) begin
        errQ <= 1'b1;
      end
    end
  end

  assign sniffActive = (stateQ == TAP_ON);
  assign sniffedPort = portQ;
  assign sniffErr    = errQ;

endmodule

// File: rtl/route_map_dp.sv
`timescale 1ns/1ps
module route_map_dp
  import route_map_pkg::*;
#(
  parameter int NUM_PORTS  = 8,
  parameter int DEST_W     = 4,
  parameter int IFACE_TILE = 15,
  parameter int RESET_DEST = 0,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobe_t        strobe,
  input  logic [PORT_W-1:0] selPort,
  input  logic [PORT_W-1:0] wrPort,
  input  logic [DEST_W-1:0] wrDest,
  input  logic              lookupReq,
  input  logic [PORT_W-1:0] lookupPort,
  output logic              lookupValid,
  output logic [DEST_W-1:0] lookupDest,
  output logic [DEST_W-1:0] backupDest
);

  localparam logic [DEST_W-1:0] IFACE_CODE = DEST_W'(IFACE_TILE);
  localparam logic [DEST_W-1:0] RST_CODE   = DEST_W'(RESET_DEST);

  logic [DEST_W-1:0] entryQ [NUM_PORTS];
  logic [DEST_W-1:0] backupQ;
  logic [DEST_W-1:0] selEntry;
  logic [DEST_W-1:0] readEntry;
  logic              validQ;
  logic [DEST_W-1:0] destQ;

  // Live table: one register per logical port.
  for (genvar i = 0; i < NUM_PORTS; i++) begin : gEntry
    logic isSel;
    logic isWr;
    assign isSel = (selPort == PORT_W'(i));
    assign isWr  = (wrPort == PORT_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryQ[i] <= RST_CODE;
      end else if (strobe.arm && isSel) begin
        entryQ[i] <= IFACE_CODE;
      end else if (strobe.disarm && isSel) begin
        entryQ[i] <= (strobe.liveWr && isWr) ? wrDest : backupQ;
      end else if (strobe.liveWr && isWr) begin
        entryQ[i] <= wrDest;
      end
    end
  end

  always_comb begin
    selEntry  = RST_CODE;
    readEntry = RST_CODE;
    for (int j = 0; j < NUM_PORTS; j++) begin
      if (selPort == PORT_W'(j)) selEntry = entryQ[j];
      if (lookupPort == PORT_W'(j)) readEntry = entryQ[j];
    end
  end

  // Shadow register holding the real destination of the tapped port.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      backupQ <= '0;
    end else if (strobe.arm) begin
      backupQ <= strobe.backupWr ? wrDest : selEntry;
    end else if (strobe.disarm) begin
      backupQ <= '0;
    end else if (strobe.backupWr) begin
      backupQ <= wrDest;
    end
  end

  // Registered lookup result.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      destQ  <= RST_CODE;
    end else begin
      validQ <= lookupReq;
      destQ  <= readEntry;
    end
  end

  assign lookupValid = validQ;
  assign lookupDest  = destQ;
  assign backupDest  = backupQ;

endmodule

// File: rtl/route_map_tap.sv
`timescale 1ns/1ps
module route_map_tap
  import route_map_pkg::*;
#(
  parameter int NUM_PORTS  = 8,
  parameter int DEST_W     = 4,
  parameter int IFACE_TILE = 15,
  parameter int RESET_DEST = 0,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupReq,
  input  logic [PORT_W-1:0] lookupPort,
  output logic              lookupValid,
  output logic [DEST_W-1:0] lookupDest,
  input  logic              wrEn,
  input  logic [PORT_W-1:0] wrPort,
  input  logic [DEST_W-1:0] wrDest,
  input  logic              sniffArm,
  input  logic              sniffDisarm,
  input  logic [PORT_W-1:0] sniffPort,
  output logic              sniffActive,
  output logic [PORT_W-1:0] sniffedPort,
  output logic [DEST_W-1:0] backupDest,
  output logic              sniffErr
);

  mapStrobe_t        strobe;
  logic [PORT_W-1:0] selPort;

  route_map_ctrl #(
    .PORT_W(PORT_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sniffArm   (sniffArm),
    .sniffDisarm(sniffDisarm),
    .sniffPort  (sniffPort),
    .wrEn       (wrEn),
    .wrPort     (wrPort),
    .strobe     (strobe),
    .selPort    (selPort),
    .sniffActive(sniffActive),
    .sniffedPort(sniffedPort),
    .sniffErr   (sniffErr)
  );

  route_map_dp #(
    .NUM_PORTS (NUM_PORTS),
    .DEST_W    (DEST_W),
    .IFACE_TILE(IFACE_TILE),
    .RESET_DEST(RESET_DEST)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .selPort    (selPort),
    .wrPort     (wrPort),
    .wrDest     (wrDest),
    .lookupReq  (lookupReq),
    .lookupPort (lookupPort),
    .lookupValid(lookupValid),
    .lookupDest (lookupDest),
    .backupDest (backupDest)
  );

endmodule

// File: rtl/route_map_tap_chk.sv
`timescale 1ns/1ps
module route_map_tap_chk #(
  parameter int PORT_W     = 3,
  parameter int DEST_W     = 4,
  parameter int IFACE_TILE = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              lookupReq,
  input logic [PORT_W-1:0] lookupPort,
  input logic              lookupValid,
  input logic [DEST_W-1:0] lookupDest,
  input logic              wrEn,
  input logic              sniffArm,
  input logic              sniffDisarm,
  input logic [PORT_W-1:0] sniffPort,
  input logic              sniffActive,
  input logic [PORT_W-1:0] sniffedPort,
  input logic [DEST_W-1:0] backupDest,
  input logic              sniffErr
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookupReq |=> lookupValid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupReq |=> !lookupValid);
  assert_arm_takes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!sniffActive && sniffArm) |=> (sniffActive && sniffedPort == $past(sniffPort)));
  assert_tapped_redirect_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lookupReq && sniffActive && !sniffArm && lookupPort == sniffedPort)
      |=> lookupDest == DEST_W'(IFACE_TILE));
  assert_backup_idle_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sniffActive |-> backupDest == '0);
  assert_backup_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sniffActive && !wrEn && !sniffDisarm) |=> $stable(backupDest));
  assert_disarm_releases_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sniffActive && sniffDisarm) |=> !sniffActive);
  assert_second_arm_refused_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sniffActive && sniffArm && !sniffDisarm)
      |=> (sniffErr && sniffActive && sniffedPort == $past(sniffedPort)));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    sniffErr |=> sniffErr);
  assert_idle_disarm_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!sniffActive && sniffDisarm && !sniffArm) |=> !sniffActive);

endmodule

bind route_map_tap route_map_tap_chk #(
  .PORT_W    (PORT_W),
  .DEST_W    (DEST_W),
  .IFACE_TILE(IFACE_TILE)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lookupReq  (lookupReq),
  .lookupPort (lookupPort),
  .lookupValid(lookupValid),
  .lookupDest (lookupDest),
  .wrEn       (wrEn),
  .sniffArm   (sniffArm),
  .sniffDisarm(sniffDisarm),
  .sniffPort  (sniffPort),
  .sniffActive(sniffActive),
  .sniffedPort(sniffedPort),
  .backupDest (backupDest),
  .sniffErr   (sniffErr)
);

// File: tb/route_map_tap_bench.sv
`timescale 1ns/1ps
module route_map_tap_bench;
  localparam int NP    = 8;
  localparam int DW    = 4;
  localparam int PW    = 3;
  localparam int IFACE = 15;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lookupReq = 1'b0;
  logic [PW-1:0] lookupPort = '0;
  logic          lookupValid;
  logic [DW-1:0] lookupDest;
  logic          wrEn = 1'b0;
  logic [PW-1:0] wrPort = '0;
  logic [DW-1:0] wrDest = '0;
  logic          sniffArm = 1'b0;
  logic          sniffDisarm = 1'b0;
  logic [PW-1:0] sniffPort = '0;
  logic          sniffActive;
  logic [PW-1:0] sniffedPort;
  logic [DW-1:0] backupDest;
  logic          sniffErr;

  always #4 clk = ~clk;  // 125 MHz

  route_map_tap #(.NUM_PORTS(NP), .DEST_W(DW), .IFACE_TILE(IFACE), .RESET_DEST(0))
  u_route_map_tap (
    .clk(clk), .rstN(rstN),
    .lookupReq(lookupReq), .lookupPort(lookupPort),
    .lookupValid(lookupValid), .lookupDest(lookupDest),
    .wrEn(wrEn), .wrPort(wrPort), .wrDest(wrDest),
    .sniffArm(sniffArm), .sniffDisarm(sniffDisarm), .sniffPort(sniffPort),
    .sniffActive(sniffActive), .sniffedPort(sniffedPort),
    .backupDest(backupDest), .sniffErr(sniffErr)
  );

  int    compared = 0;
  int    mismatched = 0;
  string curTag = "R1";
  bit    done = 1'b0;

  // Reference model: real routes per port plus tap state.
  int realD [NP];
  bit expAct;
  int expSp;
  bit expErr;
  bit expValid;
  int expLook;

  function automatic int liveOf(int p);
    return (expAct && p == expSp) ? IFACE : realD[p];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (realD[k]) realD[k] = 0;
      expAct = 0; expSp = 0; expErr = 0; expValid = 0; expLook = 0;
    end else begin
      expValid = lookupReq;
      expLook  = liveOf(int'(lookupPort));
      if (expAct) begin
        if (sniffArm) expErr = 1;
        if (sniffDisarm) expAct = 0;
      end else if (sniffArm) begin
        expAct = 1;
        expSp  = int'(sniffPort);
      end
      if (wrEn) realD[int'(wrPort)] = int'(wrDest);
    end
  end

  task automatic chk(string name, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", curTag, name, act, exp);
    end
  endtask

  // Compare every clock, at the falling edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("lookupValid", int'(lookupValid), int'(expValid));         // R2
      if (expValid) chk("lookupDest", int'(lookupDest), expLook);    // R2 R3 R4 R9
      chk("sniffActive", int'(sniffActive), int'(expAct));           // R4 R7 R10
      if (expAct) chk("sniffedPort", int'(sniffedPort), expSp);      // R4 R8
      chk("backupDest", int'(backupDest), expAct ? realD[expSp] : 0);// R5 R6
      chk("sniffErr", int'(sniffErr), int'(expErr));                 // R8
    end
  end

  task automatic step(bit lr = 0, int lp = 0, bit we = 0, int wp = 0, int wd = 0,
                      bit ar = 0, bit ds = 0, int sp = 0);
    @(posedge clk);
    #1;
    lookupReq   = lr;
    lookupPort  = PW'(lp);
    wrEn        = we;
    wrPort      = PW'(wp);
    wrDest      = DW'(wd);
    sniffArm    = ar;
    sniffDisarm = ds;
    sniffPort   = PW'(sp);
  endtask

  task automatic lookAll();
    for (int p = 0; p < NP; p++) step(.lr(1), .lp(p));
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    // R1: state during and right after reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    curTag = "R1";
    chk("lookupValid", int'(lookupValid), 0);
    chk("sniffActive", int'(sniffActive), 0);
    chk("backupDest", int'(backupDest), 0);
    chk("sniffErr", int'(sniffErr), 0);
    #1 rstN = 1'b1;
    lookAll();  // every entry reads RESET_DEST

    curTag = "R3";
    for (int p = 0; p < NP; p++) step(.we(1), .wp(p), .wd(p + 2));
    step(.we(1), .wp(7), .wd(IFACE));  // a real route to the interface tile
    lookAll();

    curTag = "R4";
    step(.ar(1), .sp(3));
    step(.lr(1), .lp(3));
    curTag = "R9";
    lookAll();

    curTag = "R6";
    step(.we(1), .wp(3), .wd(9));
    step(.lr(1), .lp(3));
    step();

    curTag = "R8";
    step(.ar(1), .sp(5));
    step(.lr(1), .lp(5));
    step(.lr(1), .lp(3));

    curTag = "R7";
    step(.ds(1));
    step(.lr(1), .lp(3));  // restored real route visible at once
    step();

    curTag = "R10";
    step(.ds(1));
    lookAll();

    curTag = "R4";
    step(.ar(1), .sp(0), .we(1), .wp(0), .wd(11));
    step(.lr(1), .lp(0));
    curTag = "R7";
    step(.ds(1), .we(1), .wp(0), .wd(12));
    step(.lr(1), .lp(0));
    step();

    curTag = "R2";
    for (int n = 0; n < 4000; n++) begin
      step(.lr($urandom_range(1, 0)), .lp($urandom_range(NP - 1, 0)),
           .we($urandom_range(3, 0) == 0), .wp($urandom_range(NP - 1, 0)),
           .wd($urandom_range(15, 0)),
           .ar($urandom_range(11, 0) == 0), .ds($urandom_range(9, 0) == 0),
           .sp($urandom_range(NP - 1, 0)));
    end
    step();
    step();
    @(negedge clk);
    #1 finishRun();
  end

endmodule